// File: doc/BRIEF.md
# Stream-Aware Cache Bypass Controller

This block holds one table entry for each memory stream slot and decides, per stream, whether that stream's requests should skip the first-level cache and go straight to the second level. A bypassed stream allocates nothing in the first level, so it cannot evict data that other code still reuses. The cache arrays, miss-handling registers and memory are outside the block. It only keeps counters and makes the decision.

A stream is set up once with its slot id and an optional footprint estimate, along with a flag that says whether the estimate is known. While the stream runs, the cache reports access events tagged with the stream id: hits, misses, and reuses of lines that this stream brought in. Each entry combines its run-time miss and reuse counts with the static footprint and holds a bypass flag. A request path reads all flags in parallel, or looks up one stream through a combinational query port. Ending a stream frees its slot.

Top module: `strm_byp_ctrl`

## Requirements
- R1: After reset every slot is unconfigured and every bypass flag reads 0.
- R2: A configure command (`cfg_valid`) clears the slot's miss and reuse counts, loads the footprint and its known flag, and puts the slot in monitoring with bypass 0. The new state is visible after the clock edge that samples the command.
- R3: Event kind `ev_kind` is encoded 2'b01 for a miss and 2'b10 for a reuse. Each increments that counter of the tagged stream. Kind 2'b00 (hit) and 2'b11 change no state. A flag change caused by an event is visible after the edge that samples the event.
- R4: A monitoring stream switches to bypass when, after a counter update, all of these hold: misses >= MISS_TH, reuses < REUSE_TH, and the footprint is unknown or >= FP_LARGE_TH (a footprint equal to the threshold counts as large).
- R5: A stream whose footprint is known and below FP_LARGE_TH never bypasses, however many misses it takes.
- R6: A bypassing stream returns to monitoring as soon as its reuse count reaches REUSE_TH. It stays in monitoring while that condition holds.
- R7: Miss and reuse counters saturate at 2^CNT_W-1 and never wrap.
- R8: An end command (`end_valid`) returns the slot to unconfigured, clears its counters and drops its flag. A later configure of that slot starts from zero counts.
- R9: Events tagged with an unconfigured stream id change no state.
- R10: `qry_bypass` shows, in the same cycle, the flag of the slot named by `qry_id`. An unconfigured slot reads 0.
- R11: When a configure and an end name the same slot in one cycle, the configure wins. An event that arrives in the same cycle as a configure or an end of its own slot is discarded.
- R12: Events change only the slot they are tagged with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_valid | input | 1 | Configure command |
| cfg_id | input | ID_W | Slot to configure |
| cfg_fp | input | FP_W | Footprint estimate in cache lines |
| cfg_fp_known | input | 1 | 1 when `cfg_fp` is meaningful |
| end_valid | input | 1 | End command |
| end_id | input | ID_W | Slot to free |
| ev_valid | input | 1 | Access event strobe |
| ev_kind | input | 2 | 00 hit, 01 miss, 10 reuse, 11 none |
| ev_id | input | ID_W | Stream tag of the event |
| qry_id | input | ID_W | Slot to look up |
| qry_bypass | output | 1 | Bypass flag of `qry_id` |
| bypass_vec | output | N_STRM | Bypass flag of every slot |

## Verification
Miss runs are counted up to one below and then exactly at the miss threshold, with the footprint unknown, equal to the large threshold and one line below it. This separates the three terms of the decision and the inclusive comparisons. Hits and the spare encoding are placed between misses, so a design that counts them is exposed. Reuses are sent one short of and at the reuse threshold to check the exit from bypass. Long runs that would wrap a plain counter show whether the counters saturate. Commands that collide in one cycle, events sent to freed slots, and traffic on neighbouring slots check priority and isolation.

// File: rtl/strm_byp_pkg.sv
package strm_byp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_MONITOR = 2'd1,
    ST_BYPASS  = 2'd2
  } strm_state_e;

  localparam logic [1:0] EVK_HIT   = 2'b00;
  localparam logic [1:0] EVK_MISS  = 2'b01;
  localparam logic [1:0] EVK_REUSE = 2'b10;

endpackage

// File: rtl/strm_byp_decide.sv
module strm_byp_decide #(
  parameter int CNT_W       = 4,
  parameter int FP_W        = 16,
  parameter int MISS_TH     = 6,
  parameter int REUSE_TH    = 2,
  parameter int FP_LARGE_TH = 1024
) (
  input  logic [CNT_W-1:0] miss_cnt,
  input  logic [CNT_W-1:0] reuse_cnt,
  input  logic [FP_W-1:0]  fp,
  input  logic             fp_known,
  output logic             want_bypass
);

  localparam logic [CNT_W-1:0] MISS_TH_C  = CNT_W'(MISS_TH);
  localparam logic [CNT_W-1:0] REUSE_TH_C = CNT_W'(REUSE_TH);
  localparam logic [FP_W-1:0]  FP_TH_C    = FP_W'(FP_LARGE_TH);

  logic many_miss;
  logic low_reuse;
  logic fp_ok;

  always_comb begin
    many_miss   = (miss_cnt >= MISS_TH_C);
    low_reuse   = (reuse_cnt < REUSE_TH_C);
    fp_ok       = !fp_known || (fp >= FP_TH_C);
    want_bypass = many_miss && low_reuse && fp_ok;
  end

endmodule

// File: rtl/strm_byp_entry.sv
module strm_byp_entry
  import strm_byp_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int FP_W        = 16,
  parameter int MISS_TH     = 6,
  parameter int REUSE_TH    = 2,
  parameter int FP_LARGE_TH = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_hit,
  input  logic [FP_W-1:0] cfg_fp,
  input  logic            cfg_fp_known,
  input  logic            end_hit,
  input  logic            miss_inc,
  input  logic            reuse_inc,
  output logic            bypass
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  strm_state_e      state_q, state_d;
  logic [CNT_W-1:0] miss_q, miss_d;
  logic [CNT_W-1:0] reuse_q, reuse_d;
  logic [FP_W-1:0]  fp_q, fp_d;
  logic             fpk_q, fpk_d;
  logic             upd_en;
  logic [CNT_W-1:0] miss_sat;
  logic [CNT_W-1:0] reuse_sat;
  logic             want_bypass;

  always_comb begin
    miss_sat  = miss_q;
    reuse_sat = reuse_q;
    if (miss_inc && (miss_q != CNT_MAX))   miss_sat  = miss_q + 1'b1;
    if (reuse_inc && (reuse_q != CNT_MAX)) reuse_sat = reuse_q + 1'b1;
  end

  strm_byp_decide #(
    .CNT_W(CNT_W), .FP_W(FP_W), .MISS_TH(MISS_TH),
    .REUSE_TH(REUSE_TH), .FP_LARGE_TH(FP_LARGE_TH)
  ) u_decide (
    .miss_cnt   (miss_sat),
    .reuse_cnt  (reuse_sat),
    .fp         (fp_q),
    .fp_known   (fpk_q),
    .want_bypass(want_bypass)
  );

  // Configure outranks end; both outrank events on this slot.
  always_comb begin
    state_d = state_q;
    miss_d  = miss_q;
    reuse_d = reuse_q;
    fp_d    = fp_q;
    fpk_d   = fpk_q;
    upd_en  = 1'b0;
    if (cfg_hit) begin
      upd_en  = 1'b1;
      state_d = ST_MONITOR;
      miss_d  = '0;
      reuse_d = '0;
      fp_d    = cfg_fp;
      fpk_d   = cfg_fp_known;
    end else if (end_hit) begin
      upd_en  = 1'b1;
      state_d = ST_IDLE;
      miss_d  = '0;
      reuse_d = '0;
      fp_d    = '0;
      fpk_d   = 1'b0;
    end else if ((state_q != ST_IDLE) && (miss_inc || reuse_inc)) begin
      upd_en  = 1'b1;
      miss_d  = miss_sat;
      reuse_d = reuse_sat;
      state_d = want_bypass ? ST_BYPASS : ST_MONITOR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      miss_q  <= '0;
      reuse_q <= '0;
      fp_q    <= '0;
      fpk_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      miss_q  <= miss_d;
      reuse_q <= reuse_d;
      fp_q    <= fp_d;
      fpk_q   <= fpk_d;
    end
  end

  assign bypass = (state_q == ST_BYPASS);

  AST_CFG_MONITOR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (state_q == ST_MONITOR) && (miss_q == '0) && (reuse_q == '0)); // R2
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && !cfg_hit) |=> (state_q == ST_IDLE) && !bypass); // R8
  AST_BYP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (miss_q >= CNT_W'(MISS_TH))); // R4
  AST_BYP_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (reuse_q < CNT_W'(REUSE_TH))); // R6
  AST_BYP_FOOTPRINT: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (!fpk_q || (fp_q >= FP_W'(FP_LARGE_TH)))); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hit && !end_hit) |=> (miss_q >= $past(miss_q)) && (reuse_q >= $past(reuse_q))); // R7
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !cfg_hit) |=> (state_q == ST_IDLE) && $stable(miss_q)); // R9
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hit && !end_hit && !miss_inc && !reuse_inc) |=> $stable(state_q) && $stable(miss_q)); // R3

endmodule

// File: rtl/strm_byp_ctrl.sv
module strm_byp_ctrl
  import strm_byp_pkg::*;
#(
  parameter int N_STRM      = 4,
  parameter int CNT_W       = 4,
  parameter int FP_W        = 16,
  parameter int MISS_TH     = 6,
  parameter int REUSE_TH    = 2,
  parameter int FP_LARGE_TH = 1024,
  localparam int ID_W       = (N_STRM > 1) ? $clog2(N_STRM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [FP_W-1:0]   cfg_fp,
  input  logic              cfg_fp_known,
  input  logic              end_valid,
  input  logic [ID_W-1:0]   end_id,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [ID_W-1:0]   ev_id,
  input  logic [ID_W-1:0]   qry_id,
  output logic              qry_bypass,
  output logic [N_STRM-1:0] bypass_vec
);

  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic ev_miss;
  logic ev_reuse;

  always_comb begin
    ev_miss  = ev_valid && (ev_kind == EVK_MISS);
    ev_reuse = ev_valid && (ev_kind == EVK_REUSE);
  end

  for (genvar g = 0; g < N_STRM; g++) begin : g_slot
    logic sel_cfg;
    logic sel_end;
    logic sel_ev;

    always_comb begin
      sel_cfg = cfg_valid && (cfg_id == ID_W'(g));
      sel_end = end_valid && (end_id == ID_W'(g));
      sel_ev  = (ev_id == ID_W'(g));
    end

    strm_byp_entry #(
      .CNT_W(CNT_W), .FP_W(FP_W), .MISS_TH(MISS_TH),
      .REUSE_TH(REUSE_TH), .FP_LARGE_TH(FP_LARGE_TH)
    ) u_entry (
      .clk         (clk),
      .rst_n       (rst_sync_q),
      .cfg_hit     (sel_cfg),
      .cfg_fp      (cfg_fp),
      .cfg_fp_known(cfg_fp_known),
      .end_hit     (sel_end),
      .miss_inc    (ev_miss && sel_ev),
      .reuse_inc   (ev_reuse && sel_ev),
      .bypass      (bypass_vec[g])
    );
  end

  always_comb begin
    qry_bypass = 1'b0;
    if (int'(qry_id) < N_STRM) qry_bypass = bypass_vec[qry_id];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sync_q |-> (bypass_vec == '0)); // R1
  AST_NEW_BYPASS_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones(bypass_vec & ~$past(bypass_vec)) <= 1); // R12

endmodule

// File: tb/strm_byp_ctrl_tb.sv
module strm_byp_ctrl_tb;

  localparam int NS   = 4;
  localparam int IDW  = 2;
  localparam int FPW  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_valid, cfg_fp_known, end_valid, ev_valid;
  logic [IDW-1:0] cfg_id, end_id, ev_id, qry_id;
  logic [FPW-1:0] cfg_fp;
  logic [1:0] ev_kind;
  logic qry_bypass;
  logic [NS-1:0] bypass_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  strm_byp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_id(cfg_id), .cfg_fp(cfg_fp), .cfg_fp_known(cfg_fp_known),
    .end_valid(end_valid), .end_id(end_id),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_id(ev_id),
    .qry_id(qry_id), .qry_bypass(qry_bypass), .bypass_vec(bypass_vec)
  );

  task automatic chk(input int id, input logic exp, input string req);
    qry_id = IDW'(id);
    #1;
    n_chk++;
    if (qry_bypass !== exp || bypass_vec[id] !== exp) begin
      n_fail++;
      $display("FAIL %s slot %0d: qry=%b vec=%b expected %b", req, id, qry_bypass, bypass_vec[id], exp);
    end
  endtask

  task automatic do_cfg(input int id, input int fp, input bit known);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_id = IDW'(id); cfg_fp = FPW'(fp); cfg_fp_known = known;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic do_end(input int id);
    @(negedge clk);
    end_valid = 1'b1; end_id = IDW'(id);
    @(negedge clk);
    end_valid = 1'b0;
  endtask

  task automatic do_ev(input logic [1:0] k, input int id, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_valid = 1'b1; ev_kind = k; ev_id = IDW'(id);
    end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < NS; s++) chk(s, 1'b0, "R1");
  endtask

  task automatic t_unknown_fp;
    do_cfg(0, 0, 1'b0);
    chk(0, 1'b0, "R2");
    do_ev(2'b01, 0, 5);
    chk(0, 1'b0, "R4 below miss threshold");
    do_ev(2'b01, 0, 1);
    chk(0, 1'b1, "R4 unknown footprint");
  endtask

  task automatic t_large_fp;
    do_cfg(1, 1024, 1'b1);
    do_ev(2'b01, 1, 6);
    chk(1, 1'b1, "R4 footprint at threshold");
  endtask

  task automatic t_small_fp;
    do_cfg(2, 1023, 1'b1);
    do_ev(2'b01, 2, 10);
    chk(2, 1'b0, "R5 small footprint");
  endtask

  task automatic t_hits;
    do_cfg(3, 0, 1'b0);
    do_ev(2'b01, 3, 5);
    do_ev(2'b00, 3, 8);
    do_ev(2'b11, 3, 4);
    chk(3, 1'b0, "R3 hits and spare kind ignored");
    do_ev(2'b01, 3, 1);
    chk(3, 1'b1, "R3 miss counted");
    do_end(3);
  endtask

  task automatic t_reuse_exit;
    do_ev(2'b10, 0, 1);
    chk(0, 1'b1, "R6 one reuse keeps bypass");
    do_ev(2'b10, 0, 1);
    chk(0, 1'b0, "R6 reuse threshold exits");
    do_ev(2'b01, 0, 3);
    chk(0, 1'b0, "R6 stays monitoring");
  endtask

  task automatic t_sat;
    do_cfg(0, 0, 1'b0);
    do_ev(2'b01, 0, 16);
    chk(0, 1'b1, "R7 miss count saturates");
    do_cfg(1, 0, 1'b0);
    do_ev(2'b01, 1, 1);
    do_ev(2'b10, 1, 16);
    do_ev(2'b01, 1, 5);
    chk(1, 1'b0, "R7 reuse count saturates");
  endtask

  task automatic t_end;
    do_end(0);
    chk(0, 1'b0, "R8 end drops flag");
    do_ev(2'b01, 0, 6);
    chk(0, 1'b0, "R8 ended slot ignores events");
    do_cfg(0, 0, 1'b0);
    do_ev(2'b01, 0, 5);
    chk(0, 1'b0, "R8 reconfig starts at zero");
    do_ev(2'b01, 0, 1);
    chk(0, 1'b1, "R8 reconfig counts again");
  endtask

  task automatic t_unconf;
    do_ev(2'b01, 3, 8);
    chk(3, 1'b0, "R9 unconfigured slot");
    chk(3, 1'b0, "R10 query unconfigured");
  endtask

  task automatic t_iso;
    do_cfg(2, 0, 1'b0);
    do_cfg(3, 0, 1'b0);
    do_ev(2'b01, 2, 6);
    chk(2, 1'b1, "R12 target slot");
    chk(3, 1'b0, "R12 neighbour untouched");
    do_ev(2'b01, 3, 5);
    chk(3, 1'b0, "R12 own count only");
    chk(2, 1'b1, "R12 other slot held");
  endtask

  task automatic t_prio;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_id = 2'd2; cfg_fp = '0; cfg_fp_known = 1'b0;
    end_valid = 1'b1; end_id = 2'd2;
    @(negedge clk);
    cfg_valid = 1'b0; end_valid = 1'b0;
    chk(2, 1'b0, "R11 cfg over end resets flag");
    do_ev(2'b01, 2, 6);
    chk(2, 1'b1, "R11 cfg won over end");
    @(negedge clk);
    cfg_valid = 1'b1; cfg_id = 2'd2; cfg_fp = '0; cfg_fp_known = 1'b0;
    ev_valid = 1'b1; ev_kind = 2'b01; ev_id = 2'd2;
    @(negedge clk);
    cfg_valid = 1'b0; ev_valid = 1'b0;
    do_ev(2'b01, 2, 5);
    chk(2, 1'b0, "R11 event beside cfg discarded");
    do_ev(2'b01, 2, 1);
    chk(2, 1'b1, "R11 counting after cfg");
    @(negedge clk);
    end_valid = 1'b1; end_id = 2'd2;
    ev_valid = 1'b1; ev_kind = 2'b01; ev_id = 2'd2;
    @(negedge clk);
    end_valid = 1'b0; ev_valid = 1'b0;
    chk(2, 1'b0, "R11 end over event");
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_valid = 1'b0; cfg_id = '0; cfg_fp = '0; cfg_fp_known = 1'b0;
    end_valid = 1'b0; end_id = '0;
    ev_valid = 1'b0; ev_kind = '0; ev_id = '0;
    qry_id = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_unknown_fp;
    t_large_fp;
    t_small_fp;
    t_hits;
    t_reuse_exit;
    t_sat;
    t_end;
    t_unconf;
    t_iso;
    t_prio;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule